// File: doc/BRIEF.md
# Multicast Pointer Distributor with Strict-Priority Output Queues

This block moves frame page pointers, not frame data, from a set of input ports to a set of output ports. An input port loads a transfer record made of a page address, a destination bitmap and a priority level. Every output port named in the bitmap copies the address into one of its own queues, chosen by the record's priority, and then removes its own bit from that input's bitmap. The input port stays busy until its bitmap is empty. A single record can therefore reach any subset of outputs, and each output takes it at its own pace.

Each output port serves its queues in strict priority order. It presents the oldest pointer of the highest non-empty queue on a valid/ready interface. When several inputs want the same output in one cycle, the output takes one of them per cycle in rotating order. A full queue stops its port from accepting records of that priority until the queue has space again.

Top module: `ptr_distributor`

## Requirements
- R1: After reset every input port reports idle (`in_busy` low) and every output port reports no pointer (`out_valid` low).
- R2: A load on an idle input captures address, bitmap and priority, and `in_busy` rises in the next cycle. A load on a busy input is ignored and changes neither the held record nor what any output later delivers.
- R3: A record loaded with an all-zero bitmap completes at once. `in_busy` stays low and no output queues anything.
- R4: Bitmap bit i selects output i. Every selected output receives the address exactly once, with the record's priority, and unselected outputs receive nothing.
- R5: An input stays busy while any bitmap bit is set. Bits that several outputs take in the same cycle are all cleared together, so a record taken by all its outputs at once frees the input one cycle after the load.
- R6: When several inputs target one output, that output takes one input per cycle. It searches upward from the input after the one it granted last, wrapping round, and starts at input 0 after reset.
- R7: Priority is a 3-bit value, 7 highest. An output presents the oldest pointer of the highest-priority non-empty queue, and pointers of the same priority leave in arrival order.
- R8: A pointer leaves its queue only on a cycle with both `out_valid` and `out_ready` high. While `out_ready` is low, the presented address and priority hold.
- R9: A queue holding DEPTH pointers refuses further records of that priority. The matching bitmap bit stays set, the input stays busy, and acceptance resumes once a pointer is popped. Other outputs of the same record are not held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_load | input | NPORT | Per-input load strobe |
| in_addr | input | NPORT*AW | Per-input page address, input i at [i*AW +: AW] |
| in_mask | input | NPORT*NPORT | Per-input destination bitmap, input i at [i*NPORT +: NPORT] |
| in_prio | input | NPORT*PW | Per-input priority, input i at [i*PW +: PW] |
| in_busy | output | NPORT | Input holds a record not yet taken by all its outputs |
| out_valid | output | NPORT | Output has a pointer to offer |
| out_ready | input | NPORT | Consumer takes the offered pointer |
| out_addr | output | NPORT*AW | Offered address per output |
| out_prio | output | NPORT*PW | Priority of the offered address per output |

## Verification
A bitmap bit that is cleared wrongly shows up on the ports one cycle after the load. Either a selected output never raises `out_valid`, or `in_busy` stays high or falls early. A wrong rotation pointer or a broken queue order is invisible until the queues are drained. Only the order of popped addresses reveals it, so the bench pops every pointer it queues and compares each one. A wrong full count appears as an input that never frees, or as a lost or duplicated pointer in the drained sequence.

// File: rtl/ptrdist_pkg.sv
package ptrdist_pkg;

  localparam int MAXN = 32;

  // Rotating search: first set request after position 'last', wrapping over n entries.
  function automatic logic [4:0] rr_pick(logic [MAXN-1:0] req, logic [4:0] last, int n);
    logic found;
    int   idx;
    logic [4:0] r;
    found = 1'b0;
    r     = '0;
    for (int k = 1; k <= MAXN; k++) begin
      if (k <= n) begin
        idx = (int'(last) + k) % n;
        if (!found && req[idx]) begin
          found = 1'b1;
          r     = 5'(idx);
        end
      end
    end
    return r;
  endfunction

  // Index of the highest set bit among the lowest n bits.
  function automatic logic [4:0] top_index(logic [MAXN-1:0] v, int n);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < MAXN; i++) begin
      if (i < n && v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/ptrdist_fifo.sv
module ptrdist_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  function automatic logic [IW-1:0] bump(logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/ptrdist_in_slot.sv
module ptrdist_in_slot #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [N-1:0]  mask_in,
  input  logic [PW-1:0] prio_in,
  input  logic [N-1:0]  clr,
  output logic          valid,
  output logic [AW-1:0] addr_q,
  output logic [N-1:0]  mask_q,
  output logic [PW-1:0] prio_q
);
  logic [N-1:0] mask_left;
  assign mask_left = mask_q & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      mask_q <= '0;
      addr_q <= '0;
      prio_q <= '0;
    end else if (!valid) begin
      if (load) begin
        addr_q <= addr_in;
        prio_q <= prio_in;
        mask_q <= mask_in;
        valid  <= |mask_in;
      end
    end else begin
      mask_q <= mask_left;
      valid  <= |mask_left;
    end
  end

  // Outputs only take bits that are present on a held record.
  assert_clr_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr & ~(mask_q & {N{valid}})) == '0);
  // While held, the bitmap only loses bits.
  assert_mask_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid)) |-> ((mask_q & ~$past(mask_q)) == '0));
  // Held record fields do not move while busy.
  assert_record_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid)) |-> ($stable(addr_q) && $stable(prio_q)));

endmodule

// File: rtl/ptrdist_out_port.sv
module ptrdist_out_port
  import ptrdist_pkg::*;
#(
  parameter int N     = 8,
  parameter int NPRIO = 8,
  parameter int AW    = 16,
  parameter int PW    = 3,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          slot_valid,
  input  logic [N-1:0]          slot_want,
  input  logic [N-1:0][AW-1:0]  slot_addr,
  input  logic [N-1:0][PW-1:0]  slot_prio,
  output logic [N-1:0]          grant,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [AW-1:0]         out_addr,
  output logic [PW-1:0]         out_prio
);
  logic [NPRIO-1:0]         q_full, q_empty, q_push, q_pop;
  logic [NPRIO-1:0][AW-1:0] q_head;
  logic [N-1:0]             req;
  logic [4:0]               last_q, pick;
  logic                     any_req;
  logic [PW-1:0]            push_prio;
  logic [AW-1:0]            push_addr;
  logic [4:0]               sel;
  logic [NPRIO-1:0]         nonempty;
  logic                     handshake;

  always_comb begin
    for (int i = 0; i < N; i++)
      req[i] = slot_valid[i] & slot_want[i] & ~q_full[slot_prio[i]];
  end

  assign any_req   = |req;
  assign pick      = rr_pick(MAXN'(req), last_q, N);
  assign grant     = any_req ? (N'(1) << pick) : '0;
  assign push_prio = slot_prio[pick];
  assign push_addr = slot_addr[pick];

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= 5'(N - 1);
    else if (any_req) last_q <= pick;
  end

  assign nonempty  = ~q_empty;
  assign out_valid = |nonempty;
  assign sel       = top_index(MAXN'(nonempty), NPRIO);
  assign out_addr  = q_head[sel];
  assign out_prio  = PW'(sel);
  assign handshake = out_valid & out_ready;

  for (genvar q = 0; q < NPRIO; q++) begin : g_queue
    assign q_push[q] = any_req && (push_prio == PW'(q));
    assign q_pop[q]  = handshake && (sel == 5'(q));
    ptrdist_fifo #(.W(AW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push[q]),
      .push_data(push_addr),
      .pop      (q_pop[q]),
      .head     (q_head[q]),
      .empty    (q_empty[q]),
      .full     (q_full[q])
    );
  end

  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  assert_grant_wanted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(slot_valid & slot_want)) == '0);
  assert_one_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_push) == $countones(grant));
  assert_single_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop) && (|q_pop == handshake));
  assert_strict_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((nonempty >> out_prio) == {{(NPRIO-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/ptr_distributor.sv
module ptr_distributor #(
  parameter int NPORT = 8,
  parameter int NPRIO = 8,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(NPRIO)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       in_load,
  input  logic [NPORT*AW-1:0]    in_addr,
  input  logic [NPORT*NPORT-1:0] in_mask,
  input  logic [NPORT*PW-1:0]    in_prio,
  output logic [NPORT-1:0]       in_busy,
  output logic [NPORT-1:0]       out_valid,
  input  logic [NPORT-1:0]       out_ready,
  output logic [NPORT*AW-1:0]    out_addr,
  output logic [NPORT*PW-1:0]    out_prio
);
  logic [NPORT-1:0]              slot_valid;
  logic [NPORT-1:0][AW-1:0]      slot_addr;
  logic [NPORT-1:0][PW-1:0]      slot_prio;
  logic [NPORT-1:0][NPORT-1:0]   slot_mask;   // [input][output]
  logic [NPORT-1:0][NPORT-1:0]   port_grant;  // [output][input]
  logic [NPORT-1:0][NPORT-1:0]   slot_clr;    // [input][output]
  logic [NPORT-1:0][NPORT-1:0]   port_want;   // [output][input]

  for (genvar i = 0; i < NPORT; i++) begin : g_xpose_i
    for (genvar p = 0; p < NPORT; p++) begin : g_xpose_p
      assign slot_clr[i][p]  = port_grant[p][i];
      assign port_want[p][i] = slot_mask[i][p];
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    ptrdist_in_slot #(.N(NPORT), .AW(AW), .PW(PW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (in_load[i]),
      .addr_in(in_addr[i*AW +: AW]),
      .mask_in(in_mask[i*NPORT +: NPORT]),
      .prio_in(in_prio[i*PW +: PW]),
      .clr    (slot_clr[i]),
      .valid  (slot_valid[i]),
      .addr_q (slot_addr[i]),
      .mask_q (slot_mask[i]),
      .prio_q (slot_prio[i])
    );
  end

  assign in_busy = slot_valid;

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    ptrdist_out_port #(.N(NPORT), .NPRIO(NPRIO), .AW(AW), .PW(PW), .DEPTH(DEPTH)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_valid(slot_valid),
      .slot_want (port_want[p]),
      .slot_addr (slot_addr),
      .slot_prio (slot_prio),
      .grant     (port_grant[p]),
      .out_ready (out_ready[p]),
      .out_valid (out_valid[p]),
      .out_addr  (out_addr[p*AW +: AW]),
      .out_prio  (out_prio[p*PW +: PW])
    );
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    assert_busy_until_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_busy[i]) |-> ($past(slot_mask[i] & ~slot_clr[i]) == '0));
    assert_zero_mask_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_load[i]) && !$past(in_busy[i]) &&
       ($past(in_mask[i*NPORT +: NPORT]) == '0)) |-> !in_busy[i]);
  end

endmodule

// File: tb/ptr_distributor_test.sv
module ptr_distributor_test;
  localparam int N = 8, AW = 16, PW = 3, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]    in_load = '0, out_ready = '0;
  logic [N*AW-1:0] in_addr = '0;
  logic [N*N-1:0]  in_mask = '0;
  logic [N*PW-1:0] in_prio = '0;
  logic [N-1:0]    in_busy, out_valid;
  logic [N*AW-1:0] out_addr;
  logic [N*PW-1:0] out_prio;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptr_distributor #(.NPORT(N), .AW(AW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_addr(in_addr),
    .in_mask(in_mask), .in_prio(in_prio), .in_busy(in_busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_prio(out_prio));

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Drive a record onto input i; strobe lasts one cycle.
  task automatic set_in(int i, logic [AW-1:0] a, logic [N-1:0] m, logic [PW-1:0] p);
    in_load[i] = 1'b1;
    in_addr[i*AW +: AW] = a;
    in_mask[i*N +: N]   = m;
    in_prio[i*PW +: PW] = p;
  endtask

  task automatic pop_expect(int p, logic [AW-1:0] a, logic [PW-1:0] pr, string req);
    check(out_valid[p] === 1'b1, req, out_valid[p], 1);
    check(out_addr[p*AW +: AW] === a, req, out_addr[p*AW +: AW], a);
    check(out_prio[p*PW +: PW] === pr, req, out_prio[p*PW +: PW], pr);
    out_ready[p] = 1'b1;
    tick();
    out_ready[p] = 1'b0;
  endtask

  task automatic t_reset();
    check(in_busy === '0, "R1", in_busy, 0);
    check(out_valid === '0, "R1", out_valid, 0);
  endtask

  task automatic t_multicast();
    set_in(2, 16'h0123, 8'b1010_0101, 3'd3);
    tick(); in_load = '0;
    check(in_busy[2] === 1'b1, "R2", in_busy[2], 1);
    tick();
    check(in_busy[2] === 1'b0, "R5", in_busy[2], 0);
    check(out_valid === 8'b1010_0101, "R4", out_valid, 8'hA5);
    for (int p = 0; p < N; p++)
      if (out_valid[p]) begin
        check(out_addr[p*AW +: AW] === 16'h0123, "R4", out_addr[p*AW +: AW], 16'h0123);
        check(out_prio[p*PW +: PW] === 3'd3, "R4", out_prio[p*PW +: PW], 3);
      end
    out_ready = 8'b1010_0101;
    tick(); out_ready = '0;
    check(out_valid === '0, "R8", out_valid, 0);
  endtask

  task automatic t_zero_mask();
    set_in(5, 16'hBEEF, 8'h00, 3'd7);
    tick(); in_load = '0;
    check(in_busy[5] === 1'b0, "R3", in_busy[5], 0);
    tick(2);
    check(out_valid === '0, "R3", out_valid, 0);
  endtask

  task automatic t_round_robin();
    set_in(4, 16'h0A04, 8'b0000_0010, 3'd2);
    set_in(5, 16'h0A05, 8'b0000_0010, 3'd2);
    tick(); in_load = '0;
    tick(3);
    set_in(2, 16'h0A02, 8'b0000_0010, 3'd2);
    set_in(6, 16'h0A06, 8'b0000_0010, 3'd2);
    tick(); in_load = '0;
    tick();
    check(in_busy[2] === 1'b1 && in_busy[6] === 1'b0, "R6", in_busy, 8'h04);
    tick(2);
    pop_expect(1, 16'h0A04, 3'd2, "R6");
    pop_expect(1, 16'h0A05, 3'd2, "R6");
    pop_expect(1, 16'h0A06, 3'd2, "R6");
    pop_expect(1, 16'h0A02, 3'd2, "R6");
    check(out_valid[1] === 1'b0, "R6", out_valid[1], 0);
  endtask

  task automatic t_priority();
    set_in(0, 16'h0B01, 8'b0000_1000, 3'd1);
    set_in(1, 16'h0B61, 8'b0000_1000, 3'd6);
    set_in(2, 16'h0B62, 8'b0000_1000, 3'd6);
    set_in(4, 16'h0B00, 8'b0000_1000, 3'd0);
    tick(); in_load = '0;
    tick(6);
    for (int k = 0; k < 3; k++) begin
      check(out_addr[3*AW +: AW] === 16'h0B61, "R8", out_addr[3*AW +: AW], 16'h0B61);
      tick();
    end
    pop_expect(3, 16'h0B61, 3'd6, "R7");
    pop_expect(3, 16'h0B62, 3'd6, "R7");
    pop_expect(3, 16'h0B01, 3'd1, "R7");
    pop_expect(3, 16'h0B00, 3'd0, "R7");
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) begin
      set_in(7, 16'h0C00 + 16'(k), 8'b0001_0000, 3'd5);
      tick(); in_load = '0;
      tick(2);
    end
    set_in(7, 16'h0CFF, 8'b0011_0000, 3'd5);
    tick(); in_load = '0;
    tick(4);
    check(in_busy[7] === 1'b1, "R9", in_busy[7], 1);
    check(out_valid[5] === 1'b1 && out_addr[5*AW +: AW] === 16'h0CFF, "R9",
          out_addr[5*AW +: AW], 16'h0CFF);
    set_in(7, 16'h0DDD, 8'b0100_0000, 3'd1);
    tick(); in_load = '0;
    tick(2);
    check(out_valid[6] === 1'b0, "R2", out_valid[6], 0);
    pop_expect(5, 16'h0CFF, 3'd5, "R4");
    pop_expect(4, 16'h0C00, 3'd5, "R9");
    tick();
    check(in_busy[7] === 1'b0, "R9", in_busy[7], 0);
    for (int k = 1; k < DEPTH; k++) pop_expect(4, 16'h0C00 + 16'(k), 3'd5, "R9");
    pop_expect(4, 16'h0CFF, 3'd5, "R9");
    check(out_valid === '0, "R2", out_valid, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_multicast();
    t_zero_mask();
    t_round_robin();
    t_priority();
    t_full();
    tick(2);
    finish_run();
  end
endmodule